// File: doc/BRIEF.md
# Dual-Clock Shift-Register Pad Reader

This block is the host side of a link to a button pad built from shift registers and driven by two clock lines. A one-cycle `start_i` pulse starts a read. The block then steps through seventeen bit periods. Each period has three timed phases, and the block samples the data line at the end of the last phase. The first sixteen samples are the button word. The seventeenth sample is the presence bit.

All timing counts a 1 µs tick enable, `tick_i`, so the system clock frequency is free. When a read ends, the block updates the raw button word, the presence flag and a byte-aligned packing of all samples, and it pulses `done_o`. A read that runs past the time budget is abandoned, and `timeout_o` and `fail_o` are raised with the completion pulse. Protocol selection and poll scheduling belong to the caller.

Top module: `dual_clock_pad_reader`

## Requirements
- R1: After reset, and whenever no read is running, both clock outputs are high. After reset, `done_o`, `fail_o`, `timeout_o`, `present_o`, `buttons_o` and `packed_o` are all zero.
- R2: A `start_i` pulse while idle begins a read. Each bit period opens with a load/shift phase, in which clock 1 is low and clock 2 is high, lasting LOAD_US ticks (default 3).
- R3: The load/shift phase is followed by GAP_US ticks (default 20) with both clocks high. Then come SETUP_US ticks (default 25) with clock 1 high and clock 2 low. The data line is captured on the tick that ends the setup phase.
- R4: A read that completes produces exactly 17 bit periods, which is 17 falling edges on clock 1. Both clocks then return to high.
- R5: `buttons_o` holds the first 16 samples MSB-first, in raw active-low form: sample 1 lands in bit 15 and sample 16 lands in bit 0.
- R6: `present_o` is 1 when the 17th sample is low and 0 when it is high.
- R7: `packed_o` (24 bits) is the 17 samples MSB-first, followed by 7 zero pad bits. Bits 23..8 hold the button word, bit 7 holds the raw presence sample, and bits 6..0 are 0.
- R8: `done_o` is a one-cycle pulse that ends every read, whether the read completes or is aborted.
- R9: `fail_o` pulses with `done_o` when button bit 7 or bit 6 was sampled as 0. Those two positions always read 1 on a working pad.
- R10: If a read has not ended after TIMEOUT_US ticks (default 5000), it is aborted on that tick. Both clocks go high, and `done_o`, `fail_o` and `timeout_o` pulse together. `present_o` is cleared.
- R11: A `start_i` pulse during a read has no effect. The read keeps its 17 periods, only one `done_o` pulse occurs, and no second read follows.
- R12: The two clock outputs are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable every microsecond |
| start_i | input | 1 | Start a read (used when idle) |
| sdata_i | input | 1 | Serial data from the pad |
| sclk1_o | output | 1 | Clock 1 to the pad, idle high |
| sclk2_o | output | 1 | Clock 2 to the pad, idle high |
| buttons_o | output | 16 | Raw active-low button word of the last read |
| present_o | output | 1 | Pad detected on the last read |
| packed_o | output | 24 | Samples packed into three bytes, MSB-first |
| done_o | output | 1 | Read finished (one-cycle pulse) |
| fail_o | output | 1 | Finished read is invalid (guard bits or timeout) |
| timeout_o | output | 1 | Read aborted by the time budget |

## Verification
Several properties are checked on every cycle: the two clocks are never low together, the clocks are high whenever the reader is idle, a sample is taken only in the setup phase, a running read does not stop early, the timeout counter stays inside its budget, `done_o` lasts one cycle, and a timeout always carries the fail flag. Phase lengths, the count of 17 clock-1 edges, bit ordering, the packing, presence decoding and guard-bit failure can only be shown by the bench's scenarios. In those scenarios a modelled pad shifts out known words, and the bench counts ticks per clock state.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_GAP, PH_SETUP} phase_e;
  localparam int unsigned GUARD_HI = 7;
  localparam int unsigned GUARD_LO = 6;
endpackage

// File: rtl/dcp_sequencer.sv
module dcp_sequencer
  import dcp_pkg::*;
#(
  parameter int unsigned LOAD_US   = 3,
  parameter int unsigned GAP_US    = 20,
  parameter int unsigned SETUP_US  = 25,
  parameter int unsigned DATA_BITS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  input  logic abort_i,
  output logic sclk1_o,
  output logic sclk2_o,
  output logic busy_o,
  output logic sample_o,
  output logic last_o
);
  localparam int unsigned TOTAL  = DATA_BITS + 1;
  localparam int unsigned MAX_US = (LOAD_US > GAP_US) ? ((LOAD_US > SETUP_US) ? LOAD_US : SETUP_US)
                                                      : ((GAP_US > SETUP_US) ? GAP_US : SETUP_US);
  localparam int unsigned CNT_W  = $clog2(MAX_US + 1);
  localparam int unsigned BIT_W  = $clog2(TOTAL + 1);

  phase_e            ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CNT_W-1:0]  lim;
  logic              ph_end;
  logic              last_bit;

  always_comb begin
    case (ph_q)
      PH_LOAD:  lim = CNT_W'(LOAD_US - 1);
      PH_GAP:   lim = CNT_W'(GAP_US - 1);
      PH_SETUP: lim = CNT_W'(SETUP_US - 1);
      default:  lim = '0;
    endcase
  end

  assign ph_end   = tick_i && (cnt_q == lim);
  assign last_bit = (bit_q == BIT_W'(TOTAL - 1));
  assign sample_o = (ph_q == PH_SETUP) && ph_end && !abort_i;
  assign last_o   = sample_o && last_bit;
  assign busy_o   = (ph_q != PH_IDLE);
  assign sclk1_o  = (ph_q != PH_LOAD);
  assign sclk2_o  = (ph_q != PH_SETUP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
    end else if (abort_i) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
    end else if (ph_q == PH_IDLE) begin
      if (start_i) begin
        ph_q  <= PH_LOAD;
        cnt_q <= '0;
        bit_q <= '0;
      end
    end else if (tick_i) begin
      if (ph_end) begin
        cnt_q <= '0;
        case (ph_q)
          PH_LOAD: ph_q <= PH_GAP;
          PH_GAP:  ph_q <= PH_SETUP;
          default: begin
            if (last_bit) ph_q <= PH_IDLE;
            else begin
              ph_q  <= PH_LOAD;
              bit_q <= bit_q + 1'b1;
            end
          end
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r12_no_dual_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sclk1_o && !sclk2_o));
  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sclk1_o && sclk2_o));
  a_r3_sample_in_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (sclk1_o && !sclk2_o && tick_i));
  a_r11_no_early_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !sample_o && !abort_i) |=> busy_o);
endmodule

// File: rtl/dcp_watchdog.sv
module dcp_watchdog #(
  parameter int unsigned TIMEOUT_US = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic busy_i,
  output logic abort_o
);
  localparam int unsigned TW = $clog2(TIMEOUT_US + 1);

  logic [TW-1:0] cnt_q;

  assign abort_o = busy_i && tick_i && (cnt_q == TW'(TIMEOUT_US - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!busy_i || abort_o) cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + 1'b1;
  end

  a_r10_budget_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < TW'(TIMEOUT_US));
endmodule

// File: rtl/dcp_capture.sv
module dcp_capture
  import dcp_pkg::*;
#(
  parameter int unsigned DATA_BITS = 16,
  parameter int unsigned PACK_W    = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sdata_i,
  input  logic                 sample_i,
  input  logic                 last_i,
  input  logic                 abort_i,
  output logic [DATA_BITS-1:0] buttons_o,
  output logic                 present_o,
  output logic [PACK_W-1:0]    packed_o,
  output logic                 done_o,
  output logic                 fail_o,
  output logic                 timeout_o
);
  localparam int unsigned TOTAL = DATA_BITS + 1;
  localparam int unsigned PAD   = PACK_W - TOTAL;

  logic [1:0]       sync_q;
  logic [TOTAL-1:0] sh_q;
  logic [TOTAL-1:0] nxt;

  // two-flop synchroniser; data is stable for the whole setup phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], sdata_i};
  end

  assign nxt = {sh_q[TOTAL-2:0], sync_q[1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      buttons_o <= '0;
      present_o <= 1'b0;
      packed_o  <= '0;
      done_o    <= 1'b0;
      fail_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      fail_o    <= 1'b0;
      timeout_o <= 1'b0;
      if (abort_i) begin
        done_o    <= 1'b1;
        fail_o    <= 1'b1;
        timeout_o <= 1'b1;
        present_o <= 1'b0;
      end else if (sample_i) begin
        sh_q <= nxt;
        if (last_i) begin
          buttons_o <= nxt[TOTAL-1:1];
          present_o <= !nxt[0];
          packed_o  <= PACK_W'(nxt) << PAD;
          done_o    <= 1'b1;
          fail_o    <= !nxt[GUARD_HI+1] || !nxt[GUARD_LO+1];
        end
      end
    end
  end

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_timeout_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (done_o && fail_o && !present_o));
endmodule

// File: rtl/dual_clock_pad_reader.sv
module dual_clock_pad_reader #(
  parameter int unsigned LOAD_US    = 3,
  parameter int unsigned GAP_US     = 20,
  parameter int unsigned SETUP_US   = 25,
  parameter int unsigned DATA_BITS  = 16,
  parameter int unsigned TIMEOUT_US = 5000,
  parameter int unsigned PACK_W     = ((DATA_BITS + 1 + 7) / 8) * 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 start_i,
  input  logic                 sdata_i,
  output logic                 sclk1_o,
  output logic                 sclk2_o,
  output logic [DATA_BITS-1:0] buttons_o,
  output logic                 present_o,
  output logic [PACK_W-1:0]    packed_o,
  output logic                 done_o,
  output logic                 fail_o,
  output logic                 timeout_o
);
  logic busy, sample, last, abort;

  dcp_sequencer #(
    .LOAD_US(LOAD_US), .GAP_US(GAP_US), .SETUP_US(SETUP_US), .DATA_BITS(DATA_BITS)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i), .abort_i(abort),
    .sclk1_o(sclk1_o), .sclk2_o(sclk2_o), .busy_o(busy), .sample_o(sample), .last_o(last)
  );

  dcp_watchdog #(.TIMEOUT_US(TIMEOUT_US)) u_wdg (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .busy_i(busy), .abort_o(abort)
  );

  dcp_capture #(.DATA_BITS(DATA_BITS), .PACK_W(PACK_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .sdata_i(sdata_i), .sample_i(sample), .last_i(last),
    .abort_i(abort), .buttons_o(buttons_o), .present_o(present_o), .packed_o(packed_o),
    .done_o(done_o), .fail_o(fail_o), .timeout_o(timeout_o)
  );
endmodule

// File: tb/dual_clock_pad_reader_tb.sv
module dual_clock_pad_reader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic start = 1'b0;
  logic sdata = 1'b1;
  logic start_t = 1'b0;
  logic sclk1, sclk2, present, done, fail, tmo;
  logic [15:0] buttons;
  logic [23:0] packed_v;
  logic t_sclk1, t_sclk2, t_present, t_done, t_fail, t_tmo;
  logic [15:0] t_buttons;
  logic [23:0] t_packed;

  int n_chk = 0, n_bad = 0;
  logic [15:0] pad_word = 16'hFFFF;
  logic        pad_pres = 1'b1;
  int fall_cnt = 0;
  int t_lo_hi = 0, t_hi_hi = 0, t_hi_lo = 0, t_all = 0;
  bit active = 0, active_t = 0;
  int dual_low = 0, done_cnt = 0;
  int tdiv = 0;

  always #2 clk = ~clk;

  dual_clock_pad_reader u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start), .sdata_i(sdata),
    .sclk1_o(sclk1), .sclk2_o(sclk2), .buttons_o(buttons), .present_o(present),
    .packed_o(packed_v), .done_o(done), .fail_o(fail), .timeout_o(tmo)
  );

  dual_clock_pad_reader #(.TIMEOUT_US(100)) u_dut_to (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start_t), .sdata_i(1'b1),
    .sclk1_o(t_sclk1), .sclk2_o(t_sclk2), .buttons_o(t_buttons), .present_o(t_present),
    .packed_o(t_packed), .done_o(t_done), .fail_o(t_fail), .timeout_o(t_tmo)
  );

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick <= (tdiv == 0);
    if (!sclk1 && !sclk2) dual_low++;
    if (done) done_cnt++;
  end

  // pad model: shift out on each clock-1 fall
  always @(negedge sclk1) begin
    if (fall_cnt < 16) sdata <= pad_word[15 - fall_cnt];
    else               sdata <= ~pad_pres;
    fall_cnt++;
  end

  always @(posedge clk) begin
    if (active && tick) begin
      case ({sclk1, sclk2})
        2'b01:   t_lo_hi++;
        2'b11:   t_hi_hi++;
        2'b10:   t_hi_lo++;
        default: ;
      endcase
    end
    if (active_t && tick) t_all++;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_read(input logic [15:0] w, input logic p, input bit poke_start,
                          output logic got_fail);
    int cyc;
    pad_word = w; pad_pres = p; fall_cnt = 0;
    t_lo_hi = 0; t_hi_hi = 0; t_hi_lo = 0; done_cnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0; active = 1;
    cyc = 0; got_fail = 1'b0;
    while (!done && cyc < 20000) begin
      if (poke_start && cyc == 500) start = 1'b1;
      else start = 1'b0;
      @(negedge clk); cyc++;
    end
    start = 1'b0;
    active = 0;
    got_fail = fail;
    check("R8 done seen", 64'(done), 64'(1));
    @(negedge clk);
    check("R8 done one cycle", 64'(done), 64'(0));
  endtask

  task automatic t_reset;
    check("R1 reset sclk1", 64'(sclk1), 64'(1));
    check("R1 reset sclk2", 64'(sclk2), 64'(1));
    check("R1 reset done", 64'({done, fail, tmo}), 64'(0));
    check("R1 reset data", 64'({buttons, present, packed_v}), 64'(0));
  endtask

  task automatic t_basic(input logic [15:0] w, input logic p);
    logic f;
    run_read(w, p, 0, f);
    check("R2 load ticks", 64'(t_lo_hi), 64'(17 * 3));
    check("R3 gap ticks", 64'(t_hi_hi), 64'(17 * 20));
    check("R3 setup ticks", 64'(t_hi_lo), 64'(17 * 25));
    check("R4 clock1 falls", 64'(fall_cnt), 64'(17));
    check("R4 idle sclk", 64'({sclk1, sclk2}), 64'(2'b11));
    check("R5 buttons", 64'(buttons), 64'(w));
    check("R6 present", 64'(present), 64'(p));
    check("R7 packed", 64'(packed_v), 64'({w, ~p, 7'b0}));
    check("R9 fail", 64'(f), 64'(!(w[7] && w[6])));
    check("R10 no timeout", 64'(tmo), 64'(0));
  endtask

  task automatic t_busy_start;
    logic f;
    run_read(16'hA5C9, 1'b1, 1, f);
    repeat (400) @(negedge clk);
    check("R11 falls", 64'(fall_cnt), 64'(17));
    check("R11 single done", 64'(done_cnt), 64'(1));
    check("R11 idle after", 64'({sclk1, sclk2}), 64'(2'b11));
    check("R11 buttons", 64'(buttons), 64'(16'hA5C9));
  endtask

  task automatic t_timeout;
    int cyc = 0;
    t_all = 0;
    @(negedge clk) start_t = 1'b1;
    @(negedge clk) start_t = 1'b0; active_t = 1;
    while (!t_done && cyc < 20000) begin @(negedge clk); cyc++; end
    active_t = 0;
    check("R10 done", 64'(t_done), 64'(1));
    check("R10 flags", 64'({t_fail, t_tmo, t_present}), 64'(3'b110));
    check("R10 budget ticks", 64'(t_all), 64'(100));
    @(negedge clk);
    check("R10 clocks idle", 64'({t_sclk1, t_sclk2}), 64'(2'b11));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_basic(16'hFFFF, 1'b1);
    t_basic(16'hA5C9, 1'b1);
    t_basic(16'h3EC0, 1'b0);
    t_basic(16'hFF3F, 1'b1);
    t_basic(16'h12BF, 1'b1);
    t_busy_start();
    t_timeout();
    check("R12 never dual low", 64'(dual_low), 64'(0));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule